// File: doc/BRIEF.md
# Double-Buffered Cell Receive Buffer

This block takes fixed-length cells from one input data port that runs on its own clock. A strobe beside the port data marks the first beat of every cell. Beats are packed into 32-bit internal words and written into one of two cell buffers. A finished cell can therefore be drained on the system clock while the next cell fills the other buffer. The cell length in bytes comes from a configuration input that all ports share. It must stay constant while traffic flows, and it must be a whole number of port beats.

Buffer ownership passes between the two clock domains through toggle synchronizers. Each toggle is carried by two flops and then edge-detected. On the system side the block flags when both buffers hold unread cells. It keeps sticky flags for short cells, long cells and dropped (overflow) cells, and a read strobe clears them.

The port side runs a four-state machine:
- WAIT: no cell in progress.
- FILL: capturing beats.
- TAIL: the configured count has been reached.
- LONG: excess beats are being discarded.

Transitions:
- A start strobe in any state enters FILL, or enters TAIL directly when the cell is one beat long.
- FILL goes to TAIL on the final beat.
- TAIL goes to LONG on the first extra beat.
- LONG stays in LONG until the next strobe.

The system side runs a three-state reader:
- IDLE goes to READ when the next buffer in turn holds a cell.
- READ goes to FREE when the last word is accepted.
- FREE hands the buffer back to the port side and returns to IDLE.

Top module: `cellrx_buf`

## Requirements
- R1: While reset is active and just after it, `rd_valid`, `sts_full`, `sts_short`, `sts_long` and `sts_ovf` are all 0.
- R2: A cell of `cfg_len` bytes (default port width 8) is delivered as ceil(cfg_len/4) words. Byte i sits in bits [8*(i mod 4)+7 : 8*(i mod 4)] of word i/4. Bytes past the cell end read as zero. `rd_last` is high exactly on the final word. Words are held stable while `rd_ready` is low, and they follow without gaps while it is high.
- R3: Two complete cells can be held at once, and they are delivered in arrival order.
- R4: A start strobe that arrives while a cell is still short of its count discards that cell and sets `sts_short`. The cell the strobe opens is captured normally.
- R5: Beats that arrive after the count is reached and before the next strobe are dropped and set `sts_long`. The cell itself is still delivered with its first `cfg_len` bytes.
- R6: A cell that starts while both buffers hold unread cells is dropped. `sts_ovf` is set when that cell's count completes. The two held cells are delivered intact.
- R7: `sts_full` is high while both buffers hold unread cells. It is low two cycles after the final word of one of them is accepted.
- R8: A one-cycle `stat_rd` clears the sticky flags at the next system edge. If a new event lands in the same cycle as the clear, the event wins. A flag never falls without `stat_rd`.
- R9: Beats with `p_valid` low are ignored. Beats without a start strobe are ignored while no cell is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_len | input | 6 | Cell length in bytes (quasi-static) |
| p_clk | input | 1 | Port clock, asynchronous to s_clk |
| p_valid | input | 1 | Port beat qualifier |
| p_soc | input | 1 | Start-of-cell strobe on the first beat |
| p_data | input | PW (8) | Port beat data |
| rd_ready | input | 1 | Readout accept |
| rd_valid | output | 1 | Readout word available |
| rd_data | output | 32 | Readout word |
| rd_last | output | 1 | Final word of the cell |
| stat_rd | input | 1 | Read-and-clear strobe for the sticky flags |
| sts_full | output | 1 | Both buffers hold unread cells |
| sts_short | output | 1 | Sticky short-cell flag |
| sts_long | output | 1 | Sticky long-cell flag |
| sts_ovf | output | 1 | Sticky overflow (dropped cell) flag |

## Verification
The sticky flag update can receive a synchronized event pulse and a `stat_rd` clear in the same system cycle. Because the event's arrival cycle cannot be placed precisely across the clock crossing, the bench holds `stat_rd` high across a short cell followed by a good cell. It then samples `sts_short` on every system cycle. Under the rule that the event wins, the flag must be seen high at least once and then fall while the clear persists. A clear-wins design never shows it.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;
    typedef enum logic [1:0] {P_WAIT, P_FILL, P_TAIL, P_LONG} port_st_t;
    typedef enum logic [1:0] {R_IDLE, R_READ, R_FREE} rd_st_t;
    localparam int EV_SHORT = 0;
    localparam int EV_LONG  = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_N     = 3;
endpackage

// File: rtl/cellrx_tsync.sv
module cellrx_tsync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], tgl_in};
    end

    assign pulse = sh[2] ^ sh[1];
endmodule

// File: rtl/cellrx_bank.sv
module cellrx_bank #(
    parameter int OUT_W  = 32,
    parameter int PW     = 8,
    parameter int DEPTH  = 14,
    parameter int AW     = 4,
    parameter int LANE_W = 2
) (
    input  logic              w_clk,
    input  logic              we,
    input  logic              wsel,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wlane,
    input  logic [PW-1:0]     wdata,
    input  logic              rsel,
    input  logic [AW-1:0]     raddr,
    output logic [OUT_W-1:0]  rdata
);
    logic [OUT_W-1:0] mem [2][DEPTH];

    // lane 0 opens a fresh word and zeroes its upper lanes
    always_ff @(posedge w_clk) begin
        if (we) begin
            if (wlane == '0)
                mem[wsel][waddr] <= OUT_W'(wdata);
            else
                mem[wsel][waddr][32'(wlane)*PW +: PW] <= wdata;
        end
    end

    // read side only touches a buffer after its handoff has synchronized
    assign rdata = mem[rsel][raddr];
endmodule

// File: rtl/cellrx_port.sv
module cellrx_port
    import cellrx_pkg::*;
#(
    parameter int PW      = 8,
    parameter int OUT_W   = 32,
    parameter int MAX_LEN = 56,
    parameter int LEN_W   = 6,
    parameter int AW      = 4,
    parameter int LANE_W  = 2
) (
    input  logic              p_clk,
    input  logic              rst_n,
    input  logic              p_valid,
    input  logic              p_soc,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        free_pulse,
    output logic              we,
    output logic              wsel,
    output logic [AW-1:0]     waddr,
    output logic [LANE_W-1:0] wlane,
    output logic [1:0]        fill_tgl,
    output logic [EV_N-1:0]   evt_tgl
);
    localparam int BEATS_MAX = MAX_LEN * 8 / PW;
    localparam int CNT_W     = $clog2(BEATS_MAX + 1);
    localparam int LANES     = OUT_W / PW;

    port_st_t         st, nxt;
    logic [CNT_W-1:0] cnt, cnt_use, beats_cfg;
    logic             drop_q, drop_now;
    logic [1:0]       full_p;
    logic             start, in_cell, last, commit;
    logic             short_evt, long_evt, ovf_evt;

    assign beats_cfg = CNT_W'((32'(cfg_len) * 8) / PW);
    assign start     = p_valid && p_soc;
    assign cnt_use   = start ? '0 : cnt;
    assign drop_now  = start ? full_p[wsel] : drop_q;
    assign in_cell   = start || (st == P_FILL && p_valid);
    assign last      = in_cell && ((cnt_use + CNT_W'(1)) == beats_cfg);
    assign commit    = last && !drop_now;
    assign ovf_evt   = last && drop_now;
    assign short_evt = start && (st == P_FILL);
    assign long_evt  = p_valid && !p_soc && (st == P_TAIL);

    assign we    = in_cell && !drop_now;
    assign waddr = AW'(32'(cnt_use) / LANES);
    assign wlane = LANE_W'(32'(cnt_use) % LANES);

    always_ff @(posedge p_clk or negedge rst_n) begin
        if (!rst_n) st <= P_WAIT;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (start) begin
            nxt = last ? P_TAIL : P_FILL;
        end else if (p_valid) begin
            unique case (st)
                P_WAIT: nxt = P_WAIT;
                P_FILL: nxt = last ? P_TAIL : P_FILL;
                P_TAIL: nxt = P_LONG;
                P_LONG: nxt = P_LONG;
            endcase
        end
    end

    always_ff @(posedge p_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            drop_q   <= 1'b0;
            wsel     <= 1'b0;
            full_p   <= '0;
            fill_tgl <= '0;
            evt_tgl  <= '0;
        end else begin
            if (in_cell) cnt <= cnt_use + CNT_W'(1);
            if (start)   drop_q <= full_p[wsel];
            if (commit) begin
                wsel           <= ~wsel;
                fill_tgl[wsel] <= ~fill_tgl[wsel];
            end
            for (int b = 0; b < 2; b++)
                full_p[b] <= (full_p[b] | (commit && wsel == 1'(b))) & ~free_pulse[b];
            evt_tgl[EV_SHORT] <= evt_tgl[EV_SHORT] ^ short_evt;
            evt_tgl[EV_LONG]  <= evt_tgl[EV_LONG]  ^ long_evt;
            evt_tgl[EV_OVF]   <= evt_tgl[EV_OVF]   ^ ovf_evt;
        end
    end
endmodule

// File: rtl/cellrx_reader.sv
module cellrx_reader
    import cellrx_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int LEN_W = 6,
    parameter int AW    = 4
) (
    input  logic             s_clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       fill_pulse,
    input  logic [EV_N-1:0]  evt_pulse,
    input  logic             rd_ready,
    input  logic             stat_rd,
    output logic             rsel,
    output logic [AW-1:0]    raddr,
    output logic             rd_valid,
    output logic             rd_last,
    output logic [1:0]       free_tgl,
    output logic             sts_full,
    output logic [EV_N-1:0]  sticky
);
    rd_st_t        st, nxt;
    logic [1:0]    sfull;
    logic [AW-1:0] ridx, last_idx;
    logic          at_last;

    assign last_idx = AW'(((32'(cfg_len) * 8 + OUT_W - 1) / OUT_W) - 1);
    assign at_last  = (ridx == last_idx);
    assign rd_valid = (st == R_READ);
    assign rd_last  = rd_valid && at_last;
    assign raddr    = ridx;
    assign sts_full = &sfull;

    always_ff @(posedge s_clk or negedge rst_n) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            R_IDLE: if (sfull[rsel])          nxt = R_READ;
            R_READ: if (rd_ready && at_last)  nxt = R_FREE;
            R_FREE:                           nxt = R_IDLE;
            default:                          nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge s_clk or negedge rst_n) begin
        if (!rst_n) begin
            ridx     <= '0;
            rsel     <= 1'b0;
            free_tgl <= '0;
            sfull    <= '0;
            sticky   <= '0;
        end else begin
            if (st == R_IDLE)
                ridx <= '0;
            else if (st == R_READ && rd_ready && !at_last)
                ridx <= ridx + AW'(1);
            if (st == R_FREE) begin
                rsel           <= ~rsel;
                free_tgl[rsel] <= ~free_tgl[rsel];
            end
            for (int b = 0; b < 2; b++)
                sfull[b] <= (sfull[b] | fill_pulse[b]) & ~(st == R_FREE && rsel == 1'(b));
            // a new event outranks a clear in the same cycle
            sticky <= evt_pulse | (sticky & ~{EV_N{stat_rd}});
        end
    end
endmodule

// File: rtl/cellrx_buf.sv
module cellrx_buf
    import cellrx_pkg::*;
#(
    parameter int PW      = 8,
    parameter int OUT_W   = 32,
    parameter int MAX_LEN = 56,
    parameter int LEN_W   = 6
) (
    input  logic             s_clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             p_clk,
    input  logic             p_valid,
    input  logic             p_soc,
    input  logic [PW-1:0]    p_data,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [OUT_W-1:0] rd_data,
    output logic             rd_last,
    input  logic             stat_rd,
    output logic             sts_full,
    output logic             sts_short,
    output logic             sts_long,
    output logic             sts_ovf
);
    localparam int LANES  = OUT_W / PW;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int DEPTH  = (MAX_LEN * 8 + OUT_W - 1) / OUT_W;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              we, wsel, rsel;
    logic [AW-1:0]     waddr, raddr;
    logic [LANE_W-1:0] wlane;
    logic [1:0]        fill_tgl, fill_pulse, free_tgl, free_pulse;
    logic [EV_N-1:0]   evt_tgl, evt_pulse, sticky;

    cellrx_port #(.PW(PW), .OUT_W(OUT_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
                  .AW(AW), .LANE_W(LANE_W)) u_port (
        .p_clk(p_clk), .rst_n(rst_n), .p_valid(p_valid), .p_soc(p_soc),
        .cfg_len(cfg_len), .free_pulse(free_pulse), .we(we), .wsel(wsel),
        .waddr(waddr), .wlane(wlane), .fill_tgl(fill_tgl), .evt_tgl(evt_tgl)
    );

    cellrx_bank #(.OUT_W(OUT_W), .PW(PW), .DEPTH(DEPTH), .AW(AW),
                  .LANE_W(LANE_W)) u_bank (
        .w_clk(p_clk), .we(we), .wsel(wsel), .waddr(waddr), .wlane(wlane),
        .wdata(p_data), .rsel(rsel), .raddr(raddr), .rdata(rd_data)
    );

    for (genvar b = 0; b < 2; b++) begin : g_buf_sync
        cellrx_tsync u_fill (.clk(s_clk), .rst_n(rst_n), .tgl_in(fill_tgl[b]), .pulse(fill_pulse[b]));
        cellrx_tsync u_free (.clk(p_clk), .rst_n(rst_n), .tgl_in(free_tgl[b]), .pulse(free_pulse[b]));
    end

    for (genvar e = 0; e < EV_N; e++) begin : g_evt_sync
        cellrx_tsync u_evt (.clk(s_clk), .rst_n(rst_n), .tgl_in(evt_tgl[e]), .pulse(evt_pulse[e]));
    end

    cellrx_reader #(.OUT_W(OUT_W), .LEN_W(LEN_W), .AW(AW)) u_rd (
        .s_clk(s_clk), .rst_n(rst_n), .cfg_len(cfg_len), .fill_pulse(fill_pulse),
        .evt_pulse(evt_pulse), .rd_ready(rd_ready), .stat_rd(stat_rd),
        .rsel(rsel), .raddr(raddr), .rd_valid(rd_valid), .rd_last(rd_last),
        .free_tgl(free_tgl), .sts_full(sts_full), .sticky(sticky)
    );

    assign sts_short = sticky[EV_SHORT];
    assign sts_long  = sticky[EV_LONG];
    assign sts_ovf   = sticky[EV_OVF];
endmodule

// File: rtl/cellrx_buf_chk.sv
module cellrx_buf_chk #(
    parameter int OUT_W = 32
) (
    input logic             s_clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             rd_last,
    input logic [OUT_W-1:0] rd_data,
    input logic             stat_rd,
    input logic             sts_full,
    input logic             sts_short,
    input logic             sts_long,
    input logic             sts_ovf
);
    // R2
    rd_hold_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R2
    rd_no_gap_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        rd_valid && rd_ready && !rd_last |=> rd_valid);

    // R7
    full_release_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        rd_valid && rd_ready && rd_last |-> ##2 !sts_full);

    // R8
    short_sticky_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        sts_short && !stat_rd |=> sts_short);

    // R8
    long_sticky_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        sts_long && !stat_rd |=> sts_long);

    // R8
    ovf_sticky_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
        sts_ovf && !stat_rd |=> sts_ovf);
endmodule

bind cellrx_buf cellrx_buf_chk #(.OUT_W(OUT_W)) u_chk (
    .s_clk(s_clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_last(rd_last), .rd_data(rd_data), .stat_rd(stat_rd), .sts_full(sts_full),
    .sts_short(sts_short), .sts_long(sts_long), .sts_ovf(sts_ovf)
);

// File: tb/cellrx_buf_test.sv
module cellrx_buf_test;
    localparam int PW = 8;
    localparam int OUT_W = 32;
    localparam int LEN_W = 6;

    logic s_clk = 1'b0, p_clk = 1'b0, rst_n = 1'b0;
    logic [LEN_W-1:0] cfg_len = 6'd10;
    logic p_valid = 1'b0, p_soc = 1'b0;
    logic [PW-1:0] p_data = '0;
    logic rd_ready = 1'b0, stat_rd = 1'b0;
    logic rd_valid, rd_last, sts_full, sts_short, sts_long, sts_ovf;
    logic [OUT_W-1:0] rd_data;

    always #2 s_clk = ~s_clk;   // 250 MHz
    always #5 p_clk = ~p_clk;   // asynchronous port clock

    cellrx_buf #(.PW(PW), .OUT_W(OUT_W), .LEN_W(LEN_W)) uut (
        .s_clk(s_clk), .rst_n(rst_n), .cfg_len(cfg_len), .p_clk(p_clk),
        .p_valid(p_valid), .p_soc(p_soc), .p_data(p_data), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .stat_rd(stat_rd), .sts_full(sts_full), .sts_short(sts_short),
        .sts_long(sts_long), .sts_ovf(sts_ovf)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0, seen = 1'b0;

    // fields: [10:3] beats sent, [2] cell delivered, [1] long flag, [0] short flag
    localparam logic [10:0] VEC [8] = '{
        {8'd10, 1'b1, 1'b0, 1'b0},
        {8'd13, 1'b1, 1'b1, 1'b0},
        {8'd4,  1'b0, 1'b0, 1'b0},
        {8'd10, 1'b1, 1'b0, 1'b1},
        {8'd1,  1'b0, 1'b0, 1'b0},
        {8'd10, 1'b1, 1'b0, 1'b1},
        {8'd11, 1'b1, 1'b1, 1'b0},
        {8'd10, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int id, input int k);
        return 8'(id * 37 + k * 3 + 1);
    endfunction

    task automatic sys_wait(input int n);
        repeat (n) @(negedge s_clk);
    endtask

    task automatic send_cell(input int id, input int beats, input bit gaps);
        for (int k = 0; k < beats; k++) begin
            if (gaps && (k % 3 == 2)) begin
                @(negedge p_clk);
                p_valid = 1'b0; p_soc = 1'b1; p_data = 8'hEE;  // ignored beat (R9)
            end
            @(negedge p_clk);
            p_valid = 1'b1; p_soc = (k == 0); p_data = pat(id, k);
        end
        @(negedge p_clk);
        p_valid = 1'b0; p_soc = 1'b0;
    endtask

    task automatic read_cell(input string req, input int id, input int len);
        int n;
        int nw;
        logic [31:0] exp;
        n = 0;
        nw = (len + 3) / 4;
        while (!rd_valid && n < 300) begin
            @(negedge s_clk);
            n++;
        end
        chk({req, " cell available"}, rd_valid, 1);
        if (!rd_valid) return;
        rd_ready = 1'b1;
        for (int w = 0; w < nw; w++) begin
            exp = '0;
            for (int b = 0; b < 4; b++)
                if (4 * w + b < len) exp[8*b +: 8] = pat(id, 4 * w + b);
            chk($sformatf("%s word %0d of cell %0d", req, w, id), rd_data, exp);
            chk($sformatf("%s last flag word %0d", req, w), rd_last, (w == nw - 1));
            @(negedge s_clk);
        end
        rd_ready = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge s_clk); stat_rd = 1'b1;
        @(negedge s_clk); stat_rd = 1'b0;
        @(negedge s_clk);
        chk("R8 flags cleared by stat_rd", {sts_short, sts_long, sts_ovf}, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge s_clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual still running expected finished by 100000 cycles");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int beats;
        repeat (5) @(negedge s_clk);
        // R1: state during reset
        chk("R1 rd_valid in reset", rd_valid, 0);
        chk("R1 flags in reset", {sts_full, sts_short, sts_long, sts_ovf}, 4'b0);
        rst_n = 1'b1;
        sys_wait(3);
        chk("R1 rd_valid after reset", rd_valid, 0);
        chk("R1 flags after reset", {sts_full, sts_short, sts_long, sts_ovf}, 4'b0);

        // R9: beats without a strobe while idle
        repeat (3) begin
            @(negedge p_clk); p_valid = 1'b1; p_soc = 1'b0; p_data = 8'h55;
        end
        @(negedge p_clk); p_valid = 1'b0;
        sys_wait(30);
        chk("R9 no cell from stray beats", rd_valid, 0);
        chk("R9 no flags from stray beats", {sts_short, sts_long, sts_ovf}, 3'b0);

        // vector table: R2 R4 R5 R9
        for (int i = 0; i < 8; i++) begin
            beats = int'(VEC[i][10:3]);
            send_cell(i + 1, beats, 1'b1);
            sys_wait(30);
            chk($sformatf("R4 short flag vec %0d", i), sts_short, VEC[i][0]);
            chk($sformatf("R5 long flag vec %0d", i), sts_long, VEC[i][1]);
            if (VEC[i][2])
                read_cell(VEC[i][1] ? "R5" : "R2", i + 1, 10);
            else
                chk($sformatf("R4 incomplete cell held back vec %0d", i), rd_valid, 0);
            clear_sts();
        end

        // R3 R6 R7: two held cells, third dropped
        send_cell(40, 10, 1'b0);
        send_cell(41, 10, 1'b0);
        sys_wait(30);
        chk("R7 full with two cells", sts_full, 1);
        chk("R6 no overflow yet", sts_ovf, 0);
        send_cell(42, 10, 1'b0);
        sys_wait(30);
        chk("R6 overflow flagged", sts_ovf, 1);
        read_cell("R3 first in order", 40, 10);
        sys_wait(2);
        chk("R7 full drops after readout", sts_full, 0);
        read_cell("R3 second in order", 41, 10);
        sys_wait(40);
        chk("R6 dropped cell absent", rd_valid, 0);
        clear_sts();

        // R8: event and clear in the same cycle, event wins
        @(negedge s_clk); stat_rd = 1'b1;
        seen = 1'b0;
        fork
            begin
                send_cell(60, 3, 1'b0);
                send_cell(61, 10, 1'b0);
            end
            begin
                repeat (80) begin
                    @(negedge s_clk);
                    if (sts_short) seen = 1'b1;
                end
            end
        join
        chk("R8 event beats concurrent clear", seen, 1);
        chk("R8 held clear empties flag", sts_short, 0);
        @(negedge s_clk); stat_rd = 1'b0;
        read_cell("R4 cell after short", 61, 10);

        // R2: length filling whole words
        rst_n = 1'b0;
        cfg_len = 6'd8;
        sys_wait(3);
        rst_n = 1'b1;
        sys_wait(3);
        send_cell(50, 8, 1'b1);
        sys_wait(30);
        read_cell("R2 whole-word cell", 50, 8);
        chk("R2 exact length not long", sts_long, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule